// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate DRAM interface and owns the command pins from reset until the memory can accept ordinary traffic. After reset it keeps clock enable low for a power-up interval. It then walks the device through a fixed, DLL-aware bring-up. First comes a precharge of all banks and an extended mode write that turns the DLL on. Next is a main mode write that also resets the DLL, then a second precharge of all banks and a programmable number of auto-refreshes. Last is a main mode write with the DLL-reset bit cleared. It raises a ready flag once every spacing rule and the DLL lock interval are met.

Every wait is a parameter in clocks, except the power-up interval, which is given in microseconds together with the clock frequency in MHz. The sequencer has no read/write scheduling and no periodic refresh. After init_done rises, its outputs rest at NOP with clock enable high, and the surrounding controller takes over the pins.

Command pin codes (cs_n, ras_n, cas_n, we_n): NOP = 0111, precharge = 0010, auto-refresh = 0001, mode write = 0000.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, and for PWRUP_CYC = CLK_MHZ*PWRUP_US cycles after reset is released (cycles 0 to PWRUP_CYC-1), cke is 0 and the pins carry NOP with ba = 0 and addr = 0.
- R2: In cycle PWRUP_CYC, cke goes to 1 with a NOP. cke then stays 1 until the next reset.
- R3: The first precharge-all comes in cycle PWRUP_CYC+2. Its code is 0010 with addr bit 10 = 1, every other addr bit 0 and ba = 0.
- R4: T_RP cycles after the first precharge-all, an extended mode write (code 0000) goes out with ba = 1 and addr = 0. An addr of 0 means DLL enabled and normal drive.
- R5: T_MRD cycles after the extended write, a main mode write goes out with ba = 0. Its addr is the mode word (R8) with bit 8 (DLL reset) set to 1.
- R6: Any two mode writes are at least T_MRD cycles apart, and a mode write comes at least T_RP cycles after the latest precharge-all.
- R7: The second precharge-all comes T_MRD cycles after the DLL-reset write. NUM_REF auto-refreshes (code 0001, addr 0, ba 0) follow it: the first T_RP cycles after that precharge, each later one T_RFC cycles after the one before.
- R8: The final main mode write (ba 0) comes T_RFC cycles after the last refresh. Its addr holds the burst code in bits 2:0 (2→1, 4→2, 8→3), 0 in bit 3 (sequential), 3 in bits 6:4 (CAS latency 3), and 0 in bit 8 and every other bit.
- R9: Every cycle not named in R3 to R8 carries NOP (0111) with ba = 0 and addr = 0.
- R10: init_done rises in cycle max(t_final + T_MRD, t_ext + DLL_LOCK + 1), where t_final is the cycle of the final mode write and t_ext is the cycle of the extended write. It stays 1 until reset.
- R11: A synchronous reset at any point returns the outputs to the R1 state and restarts the whole sequence from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_o | output | 1 | DRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization finished; sticky until reset |

## Verification
The assertions check on every cycle that no command is issued while clock enable is low and that clock enable never drops once raised. They also check the minimum spacing between mode writes and from a precharge to a mode write, that the ready flag never rises before the DLL lock count completes and never falls, and that the wait timer does not wrap. Only the bench's scenarios can show the exact cycle of each command and its address and bank contents. The same applies to the count of refreshes and to the ready cycle being the later of its two limits. The bench runs two parameter sets, one where the lock count decides the ready cycle and one where the final mode-write wait decides it. It also applies a reset in the middle of the sequence.

// File: rtl/ddr_init_pkg.sv
// Package: shared step encoding and mode-word helpers for the DRAM init sequencer.
// Assumes burst lengths of 2, 4 or 8; any other value falls back to 4.
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_CKEON,
        ST_PREA1,
        ST_EMRS,
        ST_MRS_DLLRST,
        ST_PREA2,
        ST_AREF,
        ST_MRS_FINAL,
        ST_LOCKWAIT,
        ST_DONE
    } init_step_e;

    localparam logic [2:0] CAS_LAT_CODE = 3'd3;
    localparam int         DLL_RST_BIT  = 8;
    localparam int         AUTO_PRE_BIT = 10;

    // Map a burst length to its 3-bit field code.
    function automatic logic [2:0] burst_code(input int bl);
        case (bl)
            2:       return 3'd1;
            8:       return 3'd3;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
// Module: down-counting wait timer used for power-up and inter-command gaps.
// Loads a value, counts to zero and holds there. Its reset value is the
// power-up interval minus one, so the first wait needs no explicit load.
module ddr_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load, count down or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= W'(RST_VAL);
        else if (load_i)     cnt_q <= val_i;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o); // R6

endmodule

// File: rtl/ddr_init_lock.sv
// Module: DLL lock interval counter.
// Starts on the cycle of the DLL-enable write and counts cycles up to
// DLL_LOCK, where it saturates and reports lock. Assumes DLL_LOCK >= 2.
module ddr_init_lock #(
    parameter int DLL_LOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic lock_ok_o
);

    localparam int W = $clog2(DLL_LOCK + 1);

    logic [W-1:0] cnt_q;

    // Count cycles since the DLL-enable write, saturating at the lock count.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      cnt_q <= '0;
        else if (start_i)                                cnt_q <= W'(1);
        else if (cnt_q != 0 && cnt_q != W'(DLL_LOCK))    cnt_q <= cnt_q + 1'b1;
    end

    assign lock_ok_o = (cnt_q == W'(DLL_LOCK));

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_ok_o && !start_i) |=> lock_ok_o); // R10

endmodule

// File: rtl/ddr_init_cmd_enc.sv
// Module: maps the sequencer step and phase onto the DRAM pins.
// Purely combinational. A step drives its command only in its command phase
// (wait_i low); every other cycle carries NOP with zero bank and address.
// Assumes ADDR_W >= 11 so that the precharge-all bit exists.
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2,
    parameter int BURST_LEN = 4
) (
    input  init_step_e        step_i,
    input  logic              wait_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] mode_word;

    // Build the main mode word: burst code, sequential type, CAS latency 3.
    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = burst_code(BURST_LEN);
        mode_word[3]   = 1'b0;
        mode_word[6:4] = CAS_LAT_CODE;
    end

    // Decode the step into clock enable, strobes, bank and address.
    always_comb begin
        cke_o   = (step_i != ST_PWRUP);
        cs_n_o  = 1'b0;
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        we_n_o  = 1'b1;
        ba_o    = '0;
        addr_o  = '0;
        if (!wait_i) begin
            case (step_i)
                ST_PREA1, ST_PREA2: begin
                    ras_n_o              = 1'b0;
                    we_n_o               = 1'b0;
                    addr_o[AUTO_PRE_BIT] = 1'b1;
                end
                ST_EMRS: begin
                    ras_n_o = 1'b0;
                    cas_n_o = 1'b0;
                    we_n_o  = 1'b0;
                    ba_o    = BA_W'(1);
                end
                ST_MRS_DLLRST: begin
                    ras_n_o             = 1'b0;
                    cas_n_o             = 1'b0;
                    we_n_o              = 1'b0;
                    addr_o              = mode_word;
                    addr_o[DLL_RST_BIT] = 1'b1;
                end
                ST_MRS_FINAL: begin
                    ras_n_o = 1'b0;
                    cas_n_o = 1'b0;
                    we_n_o  = 1'b0;
                    addr_o  = mode_word;
                end
                ST_AREF: begin
                    ras_n_o = 1'b0;
                    cas_n_o = 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ddr_init_seq.sv
// Module: DRAM power-up initialization sequencer (top).
// Holds CKE low for the power-up interval, then issues:
// NOP with CKE high, precharge-all, DLL-enable extended write, DLL-reset
// mode write, precharge-all, NUM_REF auto-refreshes, and the final mode write.
// Raises init_done once the last gap and the DLL lock count have both elapsed.
// Assumes T_RP, T_MRD, T_RFC >= 2, NUM_REF >= 1 and DLL_LOCK >= 2.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int PWRUP_US  = 200,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 12,
    parameter int NUM_REF   = 2,
    parameter int DLL_LOCK  = 200,
    parameter int BURST_LEN = 4,
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);

    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
    localparam int GAP_TOP   = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                              : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int MAX_LOAD  = (PWRUP_CYC > GAP_TOP) ? PWRUP_CYC : GAP_TOP;
    localparam int TMR_W     = $clog2(MAX_LOAD + 1);
    localparam int REF_W     = $clog2(NUM_REF + 1);
    localparam int CHK_MAX   = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int CHK_W     = $clog2(CHK_MAX + 1) + 1;

    init_step_e        step_q, step_next;
    logic              wait_q;
    logic [REF_W-1:0]  ref_cnt_q;
    logic              is_cmd_step, cmd_phase;
    logic              tmr_zero, lock_ok;
    logic [TMR_W-1:0]  gap_load;
    int                gap_cyc;

    // Steps that issue one command followed by a timed gap.
    always_comb begin
        is_cmd_step = (step_q != ST_PWRUP) && (step_q != ST_LOCKWAIT) && (step_q != ST_DONE);
        cmd_phase   = is_cmd_step && !wait_q;
    end

    // Select the command-to-next-command gap for the current step.
    always_comb begin
        case (step_q)
            ST_PREA1, ST_PREA2:                     gap_cyc = T_RP;
            ST_EMRS, ST_MRS_DLLRST, ST_MRS_FINAL:   gap_cyc = T_MRD;
            ST_AREF:                                gap_cyc = T_RFC;
            default:                                gap_cyc = 2;
        endcase
        gap_load = TMR_W'(gap_cyc - 2);
    end

    // Choose the step that follows a finished gap.
    always_comb begin
        case (step_q)
            ST_CKEON:      step_next = ST_PREA1;
            ST_PREA1:      step_next = ST_EMRS;
            ST_EMRS:       step_next = ST_MRS_DLLRST;
            ST_MRS_DLLRST: step_next = ST_PREA2;
            ST_PREA2:      step_next = ST_AREF;
            ST_AREF:       step_next = (ref_cnt_q == REF_W'(NUM_REF - 1)) ? ST_MRS_FINAL : ST_AREF;
            ST_MRS_FINAL:  step_next = lock_ok ? ST_DONE : ST_LOCKWAIT;
            default:       step_next = step_q;
        endcase
    end

    // Step register: power-up wait, command/gap phases, lock wait, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= ST_PWRUP;
            wait_q    <= 1'b0;
            ref_cnt_q <= '0;
        end else begin
            case (step_q)
                ST_PWRUP:    if (tmr_zero) step_q <= ST_CKEON;
                ST_LOCKWAIT: if (lock_ok)  step_q <= ST_DONE;
                ST_DONE:     ;
                default: begin
                    if (!wait_q) begin
                        wait_q <= 1'b1;
                    end else if (tmr_zero) begin
                        wait_q <= 1'b0;
                        step_q <= step_next;
                        if (step_q == ST_AREF) ref_cnt_q <= ref_cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    ddr_init_timer #(
        .W       (TMR_W),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cmd_phase),
        .val_i  (gap_load),
        .zero_o (tmr_zero)
    );

    ddr_init_lock #(
        .DLL_LOCK (DLL_LOCK)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cmd_phase && (step_q == ST_EMRS)),
        .lock_ok_o (lock_ok)
    );

    ddr_init_cmd_enc #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .BURST_LEN (BURST_LEN)
    ) u_enc (
        .step_i  (step_q),
        .wait_i  (wait_q),
        .cke_o   (cke_o),
        .cs_n_o  (cs_n_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o),
        .ba_o    (ba_o),
        .addr_o  (addr_o)
    );

    assign init_done_o = (step_q == ST_DONE);

    // ---- checks on pin-level spacing ----
    logic             is_mode, is_prea, is_active;
    logic [CHK_W-1:0] mode_gap_q, prea_gap_q;

    always_comb begin
        is_mode   = cke_o && ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000);
        is_prea   = cke_o && ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0010);
        is_active = !(ras_n_o && cas_n_o && we_n_o);
    end

    // Track cycles since the last mode write and last precharge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_gap_q <= '1;
            prea_gap_q <= '1;
        end else begin
            mode_gap_q <= is_mode ? CHK_W'(1) : ((mode_gap_q == '1) ? mode_gap_q : mode_gap_q + 1'b1);
            prea_gap_q <= is_prea ? CHK_W'(1) : ((prea_gap_q == '1) ? prea_gap_q : prea_gap_q + 1'b1);
        end
    end

    AST_NO_CMD_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        is_active |-> cke_o); // R1
    AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cke_o |=> cke_o); // R2
    AST_MODE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |-> (mode_gap_q >= CHK_W'(T_MRD))); // R6
    AST_PREA_TO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |-> (prea_gap_q >= CHK_W'(T_RP))); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o); // R10
    AST_DONE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |-> lock_ok); // R10

endmodule

// File: tb/ddr_init_seq_bench.sv
// Bench: behavioural per-cycle model of the init schedule, compared against
// two differently parameterized instances on every falling clock edge.
module ddr_init_seq_bench;

    localparam int CLK_PERIOD = 10;

    // Set A: lock count decides the ready cycle.
    localparam int A_MHZ = 1, A_US = 20, A_RP = 3, A_MRD = 2, A_RFC = 12, A_NREF = 2, A_LOCK = 40, A_BL = 4;
    // Set B: final mode-write gap decides the ready cycle.
    localparam int B_MHZ = 2, B_US = 6, B_RP = 2, B_MRD = 2, B_RFC = 5, B_NREF = 3, B_LOCK = 8, B_BL = 8;

    typedef struct packed {
        logic        cke;
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic        done;
    } pins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_en = 1'b0;
    int   tcnt = 0;
    int   n_chk = 0;
    int   n_fail = 0;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba;
    logic [11:0] a_addr;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba;
    logic [11:0] b_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr_init_seq #(
        .CLK_MHZ(A_MHZ), .PWRUP_US(A_US), .T_RP(A_RP), .T_MRD(A_MRD), .T_RFC(A_RFC),
        .NUM_REF(A_NREF), .DLL_LOCK(A_LOCK), .BURST_LEN(A_BL), .ADDR_W(12), .BA_W(2)
    ) u_ddr_init_seq (
        .clk(clk), .rst_n(rst_n), .cke_o(a_cke), .cs_n_o(a_cs), .ras_n_o(a_ras),
        .cas_n_o(a_cas), .we_n_o(a_we), .ba_o(a_ba), .addr_o(a_addr), .init_done_o(a_done)
    );

    ddr_init_seq #(
        .CLK_MHZ(B_MHZ), .PWRUP_US(B_US), .T_RP(B_RP), .T_MRD(B_MRD), .T_RFC(B_RFC),
        .NUM_REF(B_NREF), .DLL_LOCK(B_LOCK), .BURST_LEN(B_BL), .ADDR_W(12), .BA_W(2)
    ) u_ddr_init_seq_b (
        .clk(clk), .rst_n(rst_n), .cke_o(b_cke), .cs_n_o(b_cs), .ras_n_o(b_ras),
        .cas_n_o(b_cas), .we_n_o(b_we), .ba_o(b_ba), .addr_o(b_addr), .init_done_o(b_done)
    );

    // Cycles since reset release, counted on the same edges the design sees.
    always @(posedge clk) tcnt <= rst_n ? tcnt + 1 : 0;

    // Expected pins at cycle t, plus the requirement tag of the command slot.
    function automatic pins_t model(input int t, input int p, input int rp, input int mrd,
                                    input int rfc, input int nref, input int lock, input int bl,
                                    output string tag);
        pins_t e;
        int t_pre1, t_ext, t_dll, t_pre2, t_ref0, t_fin, t_rdy;
        logic [11:0] mword;
        mword = 12'h030 | ((bl == 2) ? 12'h001 : (bl == 8) ? 12'h003 : 12'h002);
        t_pre1 = p + 2;
        t_ext  = t_pre1 + rp;
        t_dll  = t_ext + mrd;
        t_pre2 = t_dll + mrd;
        t_ref0 = t_pre2 + rp;
        t_fin  = t_ref0 + nref * rfc;
        t_rdy  = (t_fin + mrd > t_ext + lock + 1) ? t_fin + mrd : t_ext + lock + 1;
        e.cke  = (t >= p);
        e.cmd  = 4'b0111;
        e.ba   = 2'd0;
        e.addr = 12'h000;
        e.done = (t >= t_rdy);
        tag    = (t == 0) ? "R11" : "R9";
        if (t == t_pre1 || t == t_pre2) begin
            e.cmd = 4'b0010; e.addr = 12'h400; tag = (t == t_pre1) ? "R3" : "R7";
        end else if (t == t_ext) begin
            e.cmd = 4'b0000; e.ba = 2'd1; tag = "R4";
        end else if (t == t_dll) begin
            e.cmd = 4'b0000; e.addr = mword | 12'h100; tag = "R5";
        end else if (t == t_fin) begin
            e.cmd = 4'b0000; e.addr = mword; tag = "R8";
        end
        for (int i = 0; i < nref; i++)
            if (t == t_ref0 + i * rfc) begin
                e.cmd = 4'b0001; tag = "R7";
            end
        return e;
    endfunction

    task automatic check(input string who, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s t=%0d actual=%0h expected=%0h", req, who, tcnt, act, exp);
        end
    endtask

    task automatic compare(input string who, input pins_t obs, input pins_t e, input string tag, input int p);
        check({who, " cke"}, (tcnt == 0) ? "R11" : (tcnt < p) ? "R1" : "R2", 32'(obs.cke), 32'(e.cke));
        check({who, " cmd"}, tag, 32'({obs.cmd, obs.ba, obs.addr}), 32'({e.cmd, e.ba, e.addr}));
        check({who, " done"}, (tcnt == 0) ? "R11" : "R10", 32'(obs.done), 32'(e.done));
    endtask

    int last_mode = -1000;
    int last_pre  = -1000;

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            pins_t ea, eb, oa, ob;
            string ta, tb;
            ea = model(tcnt, A_MHZ * A_US, A_RP, A_MRD, A_RFC, A_NREF, A_LOCK, A_BL, ta);
            eb = model(tcnt, B_MHZ * B_US, B_RP, B_MRD, B_RFC, B_NREF, B_LOCK, B_BL, tb);
            oa = {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done};
            ob = {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done};
            compare("A", oa, ea, ta, A_MHZ * A_US);
            compare("B", ob, eb, tb, B_MHZ * B_US);
            // R6: spacing of mode writes observed at the pins of set A.
            if (tcnt == 0) begin
                last_mode = -1000;
                last_pre  = -1000;
            end else if (a_cke && {a_cs, a_ras, a_cas, a_we} == 4'b0000) begin
                check("A mode-gap", "R6", 32'(tcnt - last_mode >= A_MRD), 32'd1);
                check("A pre-gap", "R6", 32'(tcnt - last_pre >= A_RP), 32'd1);
                last_mode = tcnt;
            end else if (a_cke && {a_cs, a_ras, a_cas, a_we} == 4'b0010) begin
                last_pre = tcnt;
            end
        end
    end

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stimulus: reset, full run, mid-sequence reset (R11), full run again.
    initial begin
        rst_n = 1'b0;
        run_cycles(3);
        chk_en = 1'b1;
        run_cycles(1);
        rst_n = 1'b1;
        run_cycles(90);
        rst_n = 1'b0;
        run_cycles(2);
        rst_n = 1'b1;
        run_cycles(30);
        rst_n = 1'b0;
        run_cycles(2);
        rst_n = 1'b1;
        run_cycles(90);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule